// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Generator with Border Replication

The block accepts 8-bit grayscale pixels in raster order, qualified by a data-enable and by line-start and frame-start markers, together with the frame height and width carried on two size fields. For every accepted pixel it produces one 3x3 neighbourhood of nine pixels centred on that pixel. The result is a window stream with the same height and width as the input frame, ready for a downstream filter such as an edge detector.

Two line memories hold the two most recent complete lines. Pixels outside the image are replaced by the nearest image pixel, so the first row and last row are reused as the rows beyond the top and bottom edges. The first and last columns are reused beyond the left and right edges, and corner padding takes the nearest corner pixel. A window's bottom row is only available one line after its centre arrives. The window for the last row of a frame is therefore produced from the stored lines during the idle time after the frame's last pixel.

The output markers are regenerated from the position of each window's centre. Each window carries its own line-start and frame-start flags and its own copy of the frame size, so it stays aligned with the pixel it belongs to.

Top module: `edgepad_window3`

## Requirements
- R1: While reset is high and after its release, out_de, out_hs and out_vs are low until the first window is produced.
- R2: For a frame of `rows` x `cols` pixels, exactly rows*cols windows are produced. They come in raster order of their centre pixel: all columns of centre row 0 from left to right, then row 1, and so on.
- R3: out_win holds nine pixels, with tap k in bits [8k+7:8k]. Taps 0,1,2 are the row above the centre, taps 3,4,5 are the centre row and taps 6,7,8 are the row below. Within each row the order is left, centre, right. For a centre away from every edge, the taps equal the image neighbourhood.
- R4: The padding row above image row 0 repeats row 0, and the padding row below the last image row repeats that last row.
- R5: The padding column left of column 0 repeats column 0, and the padding column right of the last column repeats the last column. A corner pad takes the value of the nearest corner image pixel.
- R6: out_hs is high exactly on windows whose centre is in column 0. out_vs is high only on the window centred on row 0, column 0. Neither is ever high without out_de.
- R7: The last row of a frame is produced with no further input. The final window of a frame appears exactly cols+2 cycles after the cycle in which the frame's last pixel is accepted.
- R8: in_de may be low for any number of cycles between lines, including none, and inside a line. A pixel flagged with in_hs starts a new line at column 0.
- R9: in_rows and in_cols are read only on the pixel flagged with in_vs and must lie in 2..MAX_ROWS and 2..MAX_COLS. Every window repeats its own frame's size on out_rows and out_cols. After a frame's last pixel, in_de must stay low for at least cols cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pix | input | 8 | Input pixel |
| in_de | input | 1 | Input pixel valid |
| in_hs | input | 1 | High with the first pixel of each line |
| in_vs | input | 1 | High with the first pixel of a frame |
| in_rows | input | 12 | Frame height, sampled with in_vs |
| in_cols | input | 12 | Frame width, sampled with in_vs |
| out_win | output | 72 | Nine window taps, tap k at bits [8k+7:8k] |
| out_de | output | 1 | Window valid |
| out_hs | output | 1 | Window centre is in column 0 |
| out_vs | output | 1 | Window centre is row 0, column 0 |
| out_rows | output | 12 | Frame height of this window's frame |
| out_cols | output | 12 | Frame width of this window's frame |

## Verification
Two actions can fall in the same cycle. One is emitting a line's right-edge window, which is held back one cycle for lack of a right neighbour. The other is loading the first column of the next line, or the first column of the last-row flush. The bench provokes this with lines driven back to back with no blanking and with a frame whose last pixel is followed immediately by the flush. A scoreboard compares every window's taps, markers and size fields against a clamped-index model of the padded frame. A separate count checks that the final window of each frame lands exactly cols+2 cycles after the last pixel.

// File: rtl/edgepad_pkg.sv
package edgepad_pkg;
    localparam int PIX_W  = 8;
    localparam int SZ_W   = 12;
    localparam int TAPS   = 9;
    localparam int WIN_W  = TAPS * PIX_W;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [SZ_W-1:0]  size_t;

    // One vertical slice of the window: pixels above, at and below the centre row
    typedef struct packed {
        pix_t top;
        pix_t mid;
        pix_t bot;
    } vcol_t;

    // A column slice with its position and its frame's size
    typedef struct packed {
        vcol_t px;
        size_t col;
        size_t row;
        size_t ncols;
        size_t nrows;
        logic  first;
        logic  last;
    } colbeat_t;

    function automatic logic [WIN_W-1:0] pack_window(vcol_t l, vcol_t c, vcol_t r);
        logic [WIN_W-1:0] w;
        w[0*PIX_W +: PIX_W] = l.top;
        w[1*PIX_W +: PIX_W] = c.top;
        w[2*PIX_W +: PIX_W] = r.top;
        w[3*PIX_W +: PIX_W] = l.mid;
        w[4*PIX_W +: PIX_W] = c.mid;
        w[5*PIX_W +: PIX_W] = r.mid;
        w[6*PIX_W +: PIX_W] = l.bot;
        w[7*PIX_W +: PIX_W] = c.bot;
        w[8*PIX_W +: PIX_W] = r.bot;
        return w;
    endfunction
endpackage

// File: rtl/edgepad_linemem.sv
module edgepad_linemem
    import edgepad_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  pix_t          wdata,
    output pix_t          rdata
);
    localparam int DEPTH = 1 << AW;

    pix_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Old content is read in the same cycle as the new value is written
    assign rdata = mem[addr];
endmodule

// File: rtl/edgepad_colgen.sv
module edgepad_colgen
    import edgepad_pkg::*;
#(
    parameter int MAX_COLS = 640,
    parameter int MAX_ROWS = 480
) (
    input  logic     clk,
    input  logic     rst,
    input  pix_t     in_pix,
    input  logic     in_de,
    input  logic     in_hs,
    input  logic     in_vs,
    input  size_t    in_rows,
    input  size_t    in_cols,
    output logic     bv,
    output colbeat_t beat
);
    localparam int    AW    = $clog2(MAX_COLS);
    localparam int    NBUF  = 2;
    localparam size_t ONE   = size_t'(1);
    localparam size_t TWO   = size_t'(2);
    localparam size_t CMAX  = size_t'(MAX_COLS);
    localparam size_t RMAX  = size_t'(MAX_ROWS);

    size_t col_q, row_q, cols_q, rows_q;
    size_t cur_col, cur_row, cur_cols, cur_rows;
    size_t fl_col;
    logic  fl_active;
    logic  [AW-1:0] mem_addr;
    pix_t  wd [NBUF];
    pix_t  rd [NBUF];

    always_comb begin
        cur_col  = (in_vs || in_hs) ? '0 : col_q;
        cur_row  = in_vs ? '0 : (in_hs ? row_q + ONE : row_q);
        cur_cols = in_vs ? in_cols : cols_q;
        cur_rows = in_vs ? in_rows : rows_q;
        mem_addr = in_de ? cur_col[AW-1:0] : fl_col[AW-1:0];
    end

    // Line store: slot 0 holds the previous line, slot 1 the one before it
    assign wd[0] = in_pix;
    assign wd[1] = rd[0];

    for (genvar g = 0; g < NBUF; g++) begin : g_line
        edgepad_linemem #(.AW(AW)) u_mem (
            .clk   (clk),
            .we    (in_de),
            .addr  (mem_addr),
            .wdata (wd[g]),
            .rdata (rd[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q     <= '0;
            row_q     <= '0;
            cols_q    <= '0;
            rows_q    <= '0;
            fl_col    <= '0;
            fl_active <= 1'b0;
            bv        <= 1'b0;
            beat      <= '0;
        end else begin
            bv <= 1'b0;
            if (in_de) begin
                col_q  <= cur_col + ONE;
                row_q  <= cur_row;
                cols_q <= cur_cols;
                rows_q <= cur_rows;
                // A live pixel on row r completes the column of centre row r-1
                bv            <= (cur_row != '0);
                beat.px.top   <= (cur_row == ONE) ? rd[0] : rd[1];
                beat.px.mid   <= rd[0];
                beat.px.bot   <= in_pix;
                beat.col      <= cur_col;
                beat.row      <= cur_row - ONE;
                beat.ncols    <= cur_cols;
                beat.nrows    <= cur_rows;
                beat.first    <= (cur_col == '0);
                beat.last     <= (cur_col == cur_cols - ONE);
                if (cur_col == cur_cols - ONE && cur_row == cur_rows - ONE) begin
                    fl_active <= 1'b1;
                    fl_col    <= '0;
                end
            end else if (fl_active) begin
                // Last image row: the row below is the last row repeated
                bv          <= 1'b1;
                beat.px.top <= rd[1];
                beat.px.mid <= rd[0];
                beat.px.bot <= rd[0];
                beat.col    <= fl_col;
                beat.row    <= rows_q - ONE;
                beat.ncols  <= cols_q;
                beat.nrows  <= rows_q;
                beat.first  <= (fl_col == '0);
                beat.last   <= (fl_col == cols_q - ONE);
                fl_col      <= fl_col + ONE;
                if (fl_col == cols_q - ONE) fl_active <= 1'b0;
            end
        end
    end

    assert_no_input_in_flush_R9: assert property (@(posedge clk) disable iff (rst)
        fl_active |-> !in_de);

    assert_flush_length_R7: assert property (@(posedge clk) disable iff (rst)
        (fl_active && !in_de && fl_col == cols_q - ONE) |=> !fl_active);

    assert_size_range_R9: assert property (@(posedge clk) disable iff (rst)
        (in_de && in_vs) |-> (in_cols >= TWO && in_cols <= CMAX &&
                              in_rows >= TWO && in_rows <= RMAX));
endmodule

// File: rtl/edgepad_hwin.sv
module edgepad_hwin
    import edgepad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bv,
    input  colbeat_t         beat,
    output logic [WIN_W-1:0] out_win,
    output logic             out_de,
    output logic             out_hs,
    output logic             out_vs,
    output size_t            out_rows,
    output size_t            out_cols
);
    localparam size_t ONE = size_t'(1);

    vcol_t    lcol;
    colbeat_t cbeat;
    logic     pend;
    logic     take_arrival;

    assign take_arrival = bv && !beat.first;

    always_ff @(posedge clk) begin
        if (rst) begin
            lcol     <= '0;
            cbeat    <= '0;
            pend     <= 1'b0;
            out_win  <= '0;
            out_de   <= 1'b0;
            out_hs   <= 1'b0;
            out_vs   <= 1'b0;
            out_rows <= '0;
            out_cols <= '0;
        end else begin
            out_de <= 1'b0;
            out_hs <= 1'b0;
            out_vs <= 1'b0;
            pend   <= take_arrival && beat.last;
            if (take_arrival) begin
                // Right neighbour has arrived: emit the window on the held centre
                out_win  <= pack_window(lcol, cbeat.px, beat.px);
                out_de   <= 1'b1;
                out_hs   <= (cbeat.col == '0);
                out_vs   <= (cbeat.col == '0) && (cbeat.row == '0);
                out_rows <= cbeat.nrows;
                out_cols <= cbeat.ncols;
            end else if (pend) begin
                // Right edge: the last column stands in for its missing neighbour
                out_win  <= pack_window(lcol, cbeat.px, cbeat.px);
                out_de   <= 1'b1;
                out_hs   <= (cbeat.col == '0);
                out_vs   <= (cbeat.col == '0) && (cbeat.row == '0);
                out_rows <= cbeat.nrows;
                out_cols <= cbeat.ncols;
            end
            if (bv) begin
                // Left edge: the first column stands in for its missing neighbour
                lcol  <= beat.first ? beat.px : cbeat.px;
                cbeat <= beat;
            end
        end
    end

    assert_pend_then_new_line_R2: assert property (@(posedge clk) disable iff (rst)
        (pend && bv) |-> beat.first);

    assert_column_order_R2: assert property (@(posedge clk) disable iff (rst)
        take_arrival |-> (beat.col == cbeat.col + ONE && beat.row == cbeat.row));

    assert_vs_with_hs_R6: assert property (@(posedge clk) disable iff (rst)
        out_vs |-> (out_hs && out_de));
endmodule

// File: rtl/edgepad_window3.sv
module edgepad_window3
    import edgepad_pkg::*;
#(
    parameter int MAX_COLS = 640,
    parameter int MAX_ROWS = 480
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [edgepad_pkg::PIX_W-1:0]         in_pix,
    input  logic                                  in_de,
    input  logic                                  in_hs,
    input  logic                                  in_vs,
    input  logic [edgepad_pkg::SZ_W-1:0]          in_rows,
    input  logic [edgepad_pkg::SZ_W-1:0]          in_cols,
    output logic [edgepad_pkg::WIN_W-1:0]         out_win,
    output logic                                  out_de,
    output logic                                  out_hs,
    output logic                                  out_vs,
    output logic [edgepad_pkg::SZ_W-1:0]          out_rows,
    output logic [edgepad_pkg::SZ_W-1:0]          out_cols
);
    logic     bv;
    colbeat_t beat;

    edgepad_colgen #(.MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS)) u_colgen (
        .clk     (clk),
        .rst     (rst),
        .in_pix  (in_pix),
        .in_de   (in_de),
        .in_hs   (in_hs),
        .in_vs   (in_vs),
        .in_rows (in_rows),
        .in_cols (in_cols),
        .bv      (bv),
        .beat    (beat)
    );

    edgepad_hwin u_hwin (
        .clk      (clk),
        .rst      (rst),
        .bv       (bv),
        .beat     (beat),
        .out_win  (out_win),
        .out_de   (out_de),
        .out_hs   (out_hs),
        .out_vs   (out_vs),
        .out_rows (out_rows),
        .out_cols (out_cols)
    );

    assert_hs_needs_de_R6: assert property (@(posedge clk) disable iff (rst)
        out_hs |-> out_de);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !out_de);
endmodule

// File: tb/edgepad_window3_bench.sv
module edgepad_window3_bench;
    import edgepad_pkg::*;

    localparam int MC = 16;
    localparam int MR = 16;

    logic clk = 1'b0;
    logic rst;
    logic [PIX_W-1:0] in_pix;
    logic in_de, in_hs, in_vs;
    logic [SZ_W-1:0] in_rows, in_cols;
    logic [WIN_W-1:0] out_win;
    logic out_de, out_hs, out_vs;
    logic [SZ_W-1:0] out_rows, out_cols;

    always #4 clk = ~clk;

    edgepad_window3 #(.MAX_COLS(MC), .MAX_ROWS(MR)) u_edgepad_window3 (
        .clk(clk), .rst(rst), .in_pix(in_pix), .in_de(in_de), .in_hs(in_hs),
        .in_vs(in_vs), .in_rows(in_rows), .in_cols(in_cols), .out_win(out_win),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
        .out_rows(out_rows), .out_cols(out_cols)
    );

    typedef struct {
        logic [WIN_W-1:0] w;
        logic hs, vs, lastf;
        int r, c, rows, cols;
        string ctag;
    } exp_t;

    exp_t q[$];
    exp_t me;
    int img [MR][MC];
    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int frm_cnt = 0;
    int last_lp = 0;
    bit timeout = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [WIN_W-1:0] act, input logic [WIN_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int clampi(int v, int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_de) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "window with nothing expected", 72'(1), 72'(0));
            end else begin
                string t;
                me = q.pop_front();
                if (me.r == 0 || me.r == me.rows - 1) t = "R4";
                else if (me.c == 0 || me.c == me.cols - 1) t = "R5";
                else t = "R3";
                check(out_win == me.w, t, $sformatf("taps r=%0d c=%0d", me.r, me.c),
                      out_win, me.w);
                check({out_hs, out_vs} == {me.hs, me.vs}, "R6", "hs/vs markers",
                      72'({out_hs, out_vs}), 72'({me.hs, me.vs}));
                check(int'(out_rows) == me.rows && int'(out_cols) == me.cols, "R9",
                      "size fields", 72'({out_rows, out_cols}),
                      72'({12'(me.rows), 12'(me.cols)}));
                if (me.r == 0 && me.c == 0) frm_cnt = 0;
                frm_cnt++;
                if (me.lastf) begin
                    check(frm_cnt == me.rows * me.cols, me.ctag, "windows per frame",
                          72'(frm_cnt), 72'(me.rows * me.cols));
                    check(cyc == last_lp + me.cols + 2, "R7", "flush timing",
                          72'(cyc - last_lp), 72'(me.cols + 2));
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        in_de = 1'b0; in_hs = 1'b0; in_vs = 1'b0;
        in_pix = 8'h5A; in_rows = 12'hABC; in_cols = 12'h123;
    endtask

    task automatic run_frame(input int w, input int h, input int fid, input int hgap,
                             input bit midgap, input int tail, input string ctag);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                img[r][c] = (r * 37 + c * 59 + fid * 101 + ((r * c) % 7) * 23 + 13) % 256;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                exp_t e;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        e.w[((dr + 1) * 3 + (dc + 1)) * PIX_W +: PIX_W] =
                            8'(img[clampi(r + dr, h - 1)][clampi(c + dc, w - 1)]);
                e.hs = (c == 0); e.vs = (r == 0 && c == 0);
                e.lastf = (r == h - 1 && c == w - 1);
                e.r = r; e.c = c; e.rows = h; e.cols = w; e.ctag = ctag;
                q.push_back(e);
            end
        end
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                @(negedge clk);
                in_de = 1'b1; in_pix = 8'(img[r][c]);
                in_hs = (c == 0); in_vs = (r == 0 && c == 0);
                // R9: size fields carry junk except on the frame-start pixel
                in_rows = (r == 0 && c == 0) ? 12'(h) : 12'(h + 3);
                in_cols = (r == 0 && c == 0) ? 12'(w) : 12'(w + 5);
                if (r == h - 1 && c == w - 1) last_lp = cyc + 1;
                if (midgap && c == 0) idle();
                if (c == w - 1 && r < h - 1) repeat (hgap) idle();
            end
        end
        repeat (tail) idle();
    endtask

    initial begin
        rst = 1'b1;
        in_de = 1'b0; in_hs = 1'b0; in_vs = 1'b0; in_pix = '0;
        in_rows = '0; in_cols = '0;
        repeat (4) @(negedge clk);
        check({out_de, out_hs, out_vs} == 3'b000, "R1", "outputs in reset",
              72'({out_de, out_hs, out_vs}), 72'(0));
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check({out_de, out_hs, out_vs} == 3'b000, "R1", "outputs after reset",
              72'({out_de, out_hs, out_vs}), 72'(0));
        fork
            begin
                run_frame(4, 3, 1, 20, 1'b0, 7, "R2");
                run_frame(7, 2, 2, 0, 1'b0, 7, "R8");   // back-to-back lines, minimal tail
                run_frame(2, 5, 3, 3, 1'b1, 2, "R8");   // gaps inside lines
                run_frame(16, 4, 4, 1, 1'b0, 20, "R2"); // widest frame
                run_frame(3, 16, 5, 2, 1'b0, 5, "R2");  // tallest frame
                run_frame(2, 2, 6, 0, 1'b0, 2, "R8");   // smallest frame
                repeat (40) idle();
            end
            begin
                repeat (20000) @(negedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++; n_err++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
        end
        check(q.size() == 0, "R2", "windows never produced", 72'(q.size()), 72'(0));
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule